// File: doc/BRIEF.md
# Second-Operand Shift and Rotate Unit

This unit forms the second ALU operand of a 32-bit data-processing instruction from its 12-bit operand field. It also produces the carry that the shifter hands to the flag logic for logical operations. It has two forms, chosen by an immediate-select input.

In the immediate form, an 8-bit constant is rotated right by an even amount to build a 32-bit value. In the register form, the value of the source register is shifted or rotated. The amount comes either from a 5-bit field in the instruction or from the low byte of a second register.

The caller reads the register file and supplies both register values (`rm_val` and `rs_val`) and the current carry flag. The unit is purely combinational. A parameter can add one output register stage.

Top module: `opnd2_shifter`

## Requirements
- R1: With `imm_sel`=1, the operand is `op_field[7:0]` zero-extended to 32 bits and rotated right by 2×`op_field[11:8]` positions.
- R2: With `imm_sel`=1, the carry output equals `carry_in` when `op_field[11:8]` is 0, and otherwise equals bit 31 of the rotated constant.
- R3: In register form with `op_field[4]`=0, the shift type is taken from `op_field[6:5]` (0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right) and the amount n from `op_field[11:7]`. For logical left, n=0 passes `rm_val` with carry `carry_in`, and n>0 gives `rm_val<<n` with carry `rm_val[32-n]`.
- R4: With `op_field[4]`=0, logical right and arithmetic right by n>0 give carry `rm_val[n-1]`, and arithmetic right fills with the sign bit. A field value of n=0 means a shift by 32, which gives all zeros (logical) or all sign bits (arithmetic), with carry `rm_val[31]`.
- R5: With `op_field[4]`=0, rotate right by n>0 gives carry equal to bit 31 of the result. Rotate right with n=0 is a one-place rotate through carry: `{carry_in, rm_val[31:1]}`, with carry `rm_val[0]`.
- R6: With `op_field[4]`=1, the amount is `rs_val[7:0]`, and `rs_val[31:8]` has no effect. An amount of 0 passes `rm_val` unchanged, with carry `carry_in`, for every shift type.
- R7: With a register amount, logical left or right by exactly 32 gives 0 with carry `rm_val[0]` (left) or `rm_val[31]` (right). An amount above 32 gives 0 with carry 0.
- R8: With a register amount of 32 or more, arithmetic right gives 32 copies of `rm_val[31]`, with carry `rm_val[31]`.
- R9: With a register amount, rotate right uses only the amount's low five bits. A nonzero amount that is a multiple of 32 leaves `rm_val` unchanged, with carry `rm_val[31]`.
- R10: In register-amount form, `op_field[7]` has no effect on the operand or the carry.
- R11: With `OUT_REG`=1, both outputs are registered and appear one clock after the inputs. While `rst_n` is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| op_field | input | 12 | Second-operand field of the instruction |
| imm_sel | input | 1 | 1 selects the rotated-constant form |
| rm_val | input | 32 | Value of the register to be shifted |
| rs_val | input | 32 | Value of the register that holds the shift amount |
| carry_in | input | 1 | Current carry flag |
| operand_out | output | 32 | Shifted, rotated or constant operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The unit holds no state apart from the optional output stage. A wrong decode or a wrong boundary rule therefore shows on `operand_out` or `carry_out` in the cycle after the offending input, and never later. Most errors sit at the edges of the amount: 0, 1, 31, 32, 33 and 255, and the rotate-through-carry encoding. The bench sweeps every immediate field, every 5-bit amount and every 8-bit register amount against a bit-by-bit model.

// File: rtl/opnd2_shifter.sv
module opnd2_shifter #(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] op_field,
  input  logic        imm_sel,
  input  logic [31:0] rm_val,
  input  logic [31:0] rs_val,
  input  logic        carry_in,
  output logic [31:0] operand_out,
  output logic        carry_out
);
  localparam int W = 32;

  typedef enum logic [1:0] {SH_LSL, SH_LSR, SH_ASR, SH_ROR} shift_t;

  shift_t     kind;
  logic       by_reg;
  logic [4:0] fld_amt;
  logic [7:0] amt;
  logic [W:0] lsl_x, lsr_x, asr_x;
  logic [W-1:0] ror_v, imm_v, nxt_op;
  logic       nxt_c;
  logic       unused_rs_hi;

  assign kind    = shift_t'(op_field[6:5]);
  assign by_reg  = op_field[4];
  assign fld_amt = op_field[11:7];
  assign unused_rs_hi = ^rs_val[31:8];

  assign amt = by_reg ? rs_val[7:0]
             : ((fld_amt == 5'd0 && (kind == SH_LSR || kind == SH_ASR)) ? 8'd32 : {3'b000, fld_amt});

  assign lsl_x = {1'b0, rm_val} << amt;
  assign lsr_x = {rm_val, 1'b0} >> amt;
  assign asr_x = (W+1)'($signed({rm_val, 1'b0}) >>> amt);
  assign ror_v = (rm_val >> amt[4:0]) | (rm_val << (6'd32 - {1'b0, amt[4:0]}));
  assign imm_v = ({24'd0, op_field[7:0]} >> {op_field[11:8], 1'b0})
               | ({24'd0, op_field[7:0]} << (6'd32 - {1'b0, op_field[11:8], 1'b0}));

  always_comb begin
    nxt_op = rm_val;
    nxt_c  = carry_in;
    if (imm_sel) begin
      nxt_op = imm_v;
      nxt_c  = (op_field[11:8] == 4'd0) ? carry_in : imm_v[W-1];
    end else if (amt == 8'd0) begin
      if (!by_reg && kind == SH_ROR) begin
        nxt_op = {carry_in, rm_val[W-1:1]};
        nxt_c  = rm_val[0];
      end
    end else begin
      case (kind)
        SH_LSL: begin nxt_op = lsl_x[W-1:0]; nxt_c = lsl_x[W]; end
        SH_LSR: begin nxt_op = lsr_x[W:1];   nxt_c = lsr_x[0]; end
        SH_ASR: begin nxt_op = asr_x[W:1];   nxt_c = asr_x[0]; end
        default: begin nxt_op = ror_v;       nxt_c = ror_v[W-1]; end
      endcase
    end
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          operand_out <= '0;
          carry_out   <= 1'b0;
        end else begin
          operand_out <= nxt_op;
          carry_out   <= nxt_c;
        end
      end
    end else begin : g_comb
      assign operand_out = nxt_op;
      assign carry_out   = nxt_c;
    end
  endgenerate

  assert_imm_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    imm_sel |-> ($countones(nxt_op) == $countones(op_field[7:0])));
  assert_imm_norot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_sel && op_field[11:8] == 4'd0) |-> (nxt_op[31:8] == 24'd0 && nxt_c == carry_in));
  assert_zero_amt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm_sel && by_reg && rs_val[7:0] == 8'd0) |-> (nxt_op == rm_val && nxt_c == carry_in));
  assert_lsl_far_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm_sel && by_reg && kind == SH_LSL && rs_val[7:0] > 8'd32) |-> (nxt_op == 32'd0 && !nxt_c));
  assert_asr_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm_sel && by_reg && kind == SH_ASR && rs_val[7:0] >= 8'd32)
      |-> ($countones({nxt_c, nxt_op}) == (rm_val[31] ? 33 : 0)));
  assert_ror_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm_sel && kind == SH_ROR && amt != 8'd0) |-> ($countones(nxt_op) == $countones(rm_val)));
  assert_rrx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm_sel && !by_reg && kind == SH_ROR && fld_amt == 5'd0)
      |-> (nxt_op[31] == carry_in && nxt_c == rm_val[0]));
endmodule

// File: tb/tb_opnd2_shifter.sv
module tb_opnd2_shifter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] op_field = '0;
  logic        imm_sel = 1'b0;
  logic [31:0] rm_val = '0;
  logic [31:0] rs_val = '0;
  logic        carry_in = 1'b0;
  logic [31:0] operand_out;
  logic        carry_out;
  int checks = 0;
  int failures = 0;

  opnd2_shifter dut (.clk(clk), .rst_n(rst_n), .op_field(op_field), .imm_sel(imm_sel),
    .rm_val(rm_val), .rs_val(rs_val), .carry_in(carry_in),
    .operand_out(operand_out), .carry_out(carry_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] pat(input int i);
    case (i)
      0: return 32'h8000_0001;
      1: return 32'h7F00_F0F5;
      2: return 32'hFFFF_FFFF;
      3: return 32'h1234_5678;
      default: return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic [32:0] model(input logic [11:0] f, input logic is, input logic [31:0] rm,
                                        input logic [31:0] rs, input logic cin);
    logic [31:0] v;
    logic c;
    int n;
    c = cin;
    if (is) begin
      v = {24'd0, f[7:0]};
      for (int k = 0; k < 2 * f[11:8]; k++) v = {v[0], v[31:1]};
      if (f[11:8] != 0) c = v[31];
      return {c, v};
    end
    v = rm;
    n = f[4] ? int'(rs[7:0]) : int'(f[11:7]);
    if (!f[4] && n == 0) begin
      if (f[6:5] == 2'd1 || f[6:5] == 2'd2) n = 32;
      else if (f[6:5] == 2'd3) return {rm[0], cin, rm[31:1]};
    end
    for (int k = 0; k < n; k++) begin
      case (f[6:5])
        2'd0: begin c = v[31]; v = {v[30:0], 1'b0}; end
        2'd1: begin c = v[0];  v = {1'b0, v[31:1]}; end
        2'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  function automatic string tag_of(input logic [11:0] f, input logic is, input logic [31:0] rs);
    if (is) return (f[11:8] == 0) ? "R2" : "R1";
    if (!f[4]) return (f[6:5] == 2'd0) ? "R3" : (f[6:5] == 2'd3) ? "R5" : "R4";
    if (f[7]) return "R10";
    if (rs[7:0] == 0) return "R6";
    if (f[6:5] == 2'd3) return "R9";
    if (f[6:5] == 2'd2 && rs[7:0] >= 32) return "R8";
    if (rs[7:0] >= 32) return "R7";
    return "R6";
  endfunction

  task automatic apply(input logic [11:0] f, input logic is, input logic [31:0] rm,
                       input logic [31:0] rs, input logic cin);
    logic [32:0] exp;
    @(negedge clk);
    op_field = f; imm_sel = is; rm_val = rm; rs_val = rs; carry_in = cin;
    exp = model(f, is, rm, rs, cin);
    @(posedge clk);
    #1;
    checks++;
    if ({carry_out, operand_out} !== exp) begin
      failures++;
      $display("FAIL %s field=%h imm=%0b rm=%h rs=%h cin=%0b actual=%0b/%h expected=%0b/%h",
        tag_of(f, is, rs), f, is, rm, rs, cin, carry_out, operand_out, exp[32], exp[31:0]);
    end
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    op_field = 12'hFFF; imm_sel = 1'b1; carry_in = 1'b1; rm_val = '1;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (operand_out !== 32'd0 || carry_out !== 1'b0) begin
      failures++;
      $display("FAIL R11 reset actual=%0b/%h expected=0/00000000", carry_out, operand_out);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2: every immediate field, both carry values
    for (int f = 0; f < 4096; f++)
      for (int c = 0; c < 2; c++)
        apply(12'(f), 1'b1, 32'hDEAD_BEEF, 32'h0, c[0]);

    // R3 R4 R5: every type and every 5-bit amount
    for (int t = 0; t < 4; t++)
      for (int a = 0; a < 32; a++)
        for (int p = 0; p < 5; p++)
          for (int c = 0; c < 2; c++)
            apply({5'(a), 2'(t), 1'b0, 4'h3}, 1'b0, pat(p), 32'h0, c[0]);

    // R6 R7 R8 R9: every 8-bit register amount, noisy upper bits of rs
    for (int t = 0; t < 4; t++)
      for (int a = 0; a < 256; a++)
        for (int p = 0; p < 4; p++)
          apply({4'h5, 1'b0, 2'(t), 1'b1, 4'h2}, 1'b0, pat(p),
                {24'hA5C3_96 ^ 24'(a * 77), 8'(a)}, p[0]);

    // R10: bit 7 set in register-amount form
    for (int t = 0; t < 4; t++)
      for (int a = 0; a < 40; a++)
        for (int p = 0; p < 4; p++)
          apply({4'h9, 1'b1, 2'(t), 1'b1, 4'h7}, 1'b0, pat(p), {24'hFFFFFF, 8'(a)}, ~p[0]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule